// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link: a serial data output, a serial data input and a shift clock. It transmits and receives at the same time. Writing a byte into the data register starts a transfer. Each clock cycle of the link drives out one bit of that byte and samples one incoming bit into the same register. After eight link clocks the received byte can be read back, and a single-cycle completion request tells the surrounding logic to service the port.

The shift clock either comes from inside the block or from an external master. When it comes from inside, it is the system clock divided by 8, 16, 32 or 64. In that mode the block drives the clock pin, stops on its own after eight bits, parks the clock high and releases its data output. When the clock comes from an external master, the block only follows that clock. It still signals completion after eight edges, but it keeps shifting for as long as edges arrive. A small mode register selects the clock source, the divider and the bit order.

Top module: `sync_serial_port`

## Requirements
- R1: After reset `busy`=0, `irq`=0, `sck_out`=1, `sck_oe`=0, `sdo_oe`=1 and `rd_data`=0. The mode register resets to external clock, divider code 0 and LSB first.
- R2: A cycle with `mode_wr`=1 loads `mode_wdata` into the mode register. Bits [1:0] select the divide code `s`, bit 2 set means internal clock, and bit 3 set means MSB first.
- R3: A cycle with `wr_en`=1 loads `wr_data` into the shift register, arms an eight-bit count and sets `busy`. In the cycle after the write, `sck_out` is high.
- R4: The serial output changes only on a falling shift-clock edge. On each rising edge the block samples `sdi` and shifts the register one place.
- R5: With the internal clock, `sck_out` first falls `4<<s` system cycles after the write. It has a period of `8<<s` cycles, so `irq` is seen `16*(4<<s)` cycles after the write.
- R6: With the internal clock, the eighth rising edge ends the transfer. At that point `busy` drops, `sck_out` stays high until the next write, and `irq` pulses.
- R7: `sdo_oe` is high whenever the external clock is selected or a transfer is in progress. With the internal clock and no transfer in progress, it is low.
- R8: With LSB-first order, bit 0 goes out first and received bits enter at bit 7. With MSB-first order, bit 7 goes out first and received bits enter at bit 0. Either way, after eight bits `rd_data` equals the received byte.
- R9: With the external clock, `sck_oe`=0 and the block acts on synchronised edges of `sck_in`. `irq` pulses once after eight rising edges, and later edges keep shifting data in without raising another request.
- R10: A data write in the same cycle as the eighth rising edge takes precedence. No request is raised for the old byte, and a full new transfer starts.
- R11: `irq` is high for exactly one system cycle per completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Shift register contents (received byte) |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode value: [1:0] divide code, [2] internal clock, [3] MSB first |
| busy | output | 1 | Byte transfer in progress |
| irq | output | 1 | One-cycle completion request |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data in |
| sck_in | input | 1 | Shift clock pin level (external clock) |
| sck_out | output | 1 | Shift clock driven by the block |
| sck_oe | output | 1 | Output enable for `sck_out` |

## Verification
A data write can land in the same system cycle as the shift clock's eighth rising edge, so a new load competes with the completion of the previous byte. The bench provokes this case by counting exactly `16*(4<<s)-1` cycles after a first write before issuing a second one. It then judges the result at the ports: no request may appear for the abandoned byte, and exactly one request must follow after a further full byte time, carrying the newly received data. The same counting also pins down when the first falling edge and the completion occur for every divide code and both bit orders.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int SSP_SEL_W = 2;

  typedef struct packed {
    logic                 msb_first;
    logic                 int_clk;
    logic [SSP_SEL_W-1:0] div_sel;
  } ssp_mode_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int BASE_HALF = 4,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic [CNT_W:0]   half;
  logic             term;

  always_comb begin
    half = (CNT_W+1)'(BASE_HALF) << div_sel;
    term = run && ({1'b0, cnt_q} == (half - (CNT_W+1)'(1)));
  end

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (load) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (run) begin
      if (term) begin
        cnt_d = '0;
        sck_d = ~sck_q;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck  = sck_q;
  assign rise = term & ~sck_q & ~load;
  assign fall = term & sck_q & ~load;
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rise,
  input  logic         fall,
  input  logic         msb_first,
  input  logic         sdi,
  output logic [W-1:0] data,
  output logic         sdo,
  output logic         busy,
  output logic         done
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             done_q, done_d;
  logic             sdo_q, sdo_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    done_d = 1'b0;
    sdo_d  = sdo_q;
    if (load) begin
      sh_d  = load_data;
      cnt_d = CNT_W'(W - 1);
      act_d = 1'b1;
    end else begin
      if (fall) begin
        sdo_d = msb_first ? sh_q[W-1] : sh_q[0];
      end
      if (rise) begin
        sh_d = msb_first ? {sh_q[W-2:0], sdi} : {sdi, sh_q[W-1:1]};
        if (act_q) begin
          if (cnt_q == '0) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      sdo_q  <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      done_q <= done_d;
      sdo_q  <= sdo_d;
    end
  end

  assign data = sh_q;
  assign sdo  = sdo_q;
  assign busy = act_q;
  assign done = done_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BASE_HALF   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 mode_wr,
  input  logic [SSP_SEL_W+1:0] mode_wdata,
  output logic                 busy,
  output logic                 irq,
  output logic                 sdo,
  output logic                 sdo_oe,
  input  logic                 sdi,
  input  logic                 sck_in,
  output logic                 sck_out,
  output logic                 sck_oe
);
  ssp_mode_t mode_q, mode_d;
  logic      int_mode;
  logic      gen_rise, gen_fall, gen_sck;
  logic      ext_rise, ext_fall;
  logic      sh_rise, sh_fall;
  logic      xfer_busy;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) mode_d = ssp_mode_t'(mode_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign int_mode = mode_q.int_clk;

  ssp_clkgen #(
    .BASE_HALF (BASE_HALF),
    .SEL_W     (SSP_SEL_W)
  ) clkgen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_en),
    .run     (xfer_busy & int_mode),
    .div_sel (mode_q.div_sel),
    .sck     (gen_sck),
    .rise    (gen_rise),
    .fall    (gen_fall)
  );

  ssp_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sck_in),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  always_comb begin
    sh_rise = int_mode ? gen_rise : ext_rise;
    sh_fall = int_mode ? gen_fall : ext_fall;
  end

  ssp_shifter #(
    .W (DATA_W)
  ) shifter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_en),
    .load_data (wr_data),
    .rise      (sh_rise),
    .fall      (sh_fall),
    .msb_first (mode_q.msb_first),
    .sdi       (sdi),
    .data      (rd_data),
    .sdo       (sdo),
    .busy      (xfer_busy),
    .done      (irq)
  );

  assign busy    = xfer_busy;
  assign sck_out = gen_sck;
  assign sck_oe  = int_mode;
  assign sdo_oe  = ~int_mode | xfer_busy;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic irq,
  input logic busy,
  input logic sck_out,
  input logic sdo,
  input logic sdo_oe,
  input logic int_mode
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R11

  AST_IRQ_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy); // R6

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (busy && sck_out)); // R3

  AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && !busy) |-> sck_out); // R6

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && !busy) |-> !sdo_oe); // R7

  AST_EXT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_mode |-> sdo_oe); // R7

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && $past(int_mode) && !$stable(sdo)) |-> ($past(sck_out) && !sck_out)); // R4
endmodule

bind sync_serial_port ssp_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .irq      (irq),
  .busy     (busy),
  .sck_out  (sck_out),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe),
  .int_mode (int_mode)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       mode_wr = 1'b0;
  logic [3:0] mode_wdata = '0;
  logic       busy, irq, sdo, sdo_oe, sck_out, sck_oe;
  logic       sck_in = 1'b1;
  logic       sdi;
  logic       sdi_slave = 1'b0;
  logic       sdi_ext = 1'b0;
  logic       ext_sel = 1'b0;

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0;
  bit finished = 0;

  logic       s_msb = 1'b0;
  logic [7:0] s_rx = '0;
  logic [7:0] s_cap = '0;
  int         fidx = 0;
  int         ridx = 0;
  logic       prev_sck = 1'b1;

  always #2 clk = ~clk;

  assign sdi = ext_sel ? sdi_ext : sdi_slave;

  sync_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .busy(busy), .irq(irq),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe)
  );

  // request counter and a slave model that follows the block's own clock
  always @(posedge clk) begin
    #1;
    if (irq) irq_cnt++;
    if (wr_en) begin
      fidx = 0;
      ridx = 0;
      prev_sck = sck_out;
    end else begin
      if (prev_sck && !sck_out) begin
        if (fidx < 8) sdi_slave = s_msb ? s_rx[7-fidx] : s_rx[fidx];
        fidx++;
      end
      if (!prev_sck && sck_out) begin
        if (ridx < 8) s_cap[s_msb ? 7-ridx : ridx] = sdo;
        ridx++;
      end
      prev_sck = sck_out;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(output int n, output int first);
    n = 0; first = -1;
    while (!irq && n < 4000) begin
      @(negedge clk);
      n++;
      if (first < 0 && !sck_out) first = n;
    end
  endtask

  task automatic xfer_int(input int sel, input logic msb, input logic [7:0] tx, input logic [7:0] rx);
    int n, first, half, c0;
    half = 4 << sel;
    set_mode({msb, 1'b1, sel[1:0]});
    s_msb = msb; s_rx = rx; s_cap = '0;
    c0 = irq_cnt;
    wr(tx);
    chk("R3 busy after write", busy, 1);
    chk("R3 sck high after write", sck_out, 1);
    chk("R7 sdo_oe during transfer", sdo_oe, 1);
    wait_irq(n, first);
    chk("R5 first falling edge delay", first, half);
    chk("R2 R5 cycles to completion", n, 16 * half);
    chk("R8 received byte", rd_data, rx);
    chk("R4 R8 transmitted byte", s_cap, tx);
    chk("R6 busy cleared", busy, 0);
    chk("R6 sck parked high", sck_out, 1);
    chk("R7 sdo released", sdo_oe, 0);
    @(negedge clk);
    chk("R11 irq single cycle", irq, 0);
    repeat (4) @(negedge clk);
    chk("R11 one request per byte", irq_cnt - c0, 1);
  endtask

  task automatic ext_byte(input logic msb, input logic [7:0] rx, output logic [7:0] cap);
    cap = '0;
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0;
      sdi_ext = msb ? rx[7-i] : rx[i];
      repeat (6) @(negedge clk);
      cap[msb ? 7-i : i] = sdo;
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic xfer_ext(input logic msb, input logic [7:0] tx, input logic [7:0] rx, input logic [7:0] rx2);
    logic [7:0] cap;
    int c0;
    ext_sel = 1'b1;
    set_mode({msb, 3'b000});
    chk("R9 sck not driven", sck_oe, 0);
    chk("R7 sdo driven in external mode", sdo_oe, 1);
    c0 = irq_cnt;
    wr(tx);
    chk("R3 busy after external write", busy, 1);
    ext_byte(msb, rx, cap);
    chk("R9 R8 external received byte", rd_data, rx);
    chk("R9 R4 external transmitted byte", cap, tx);
    chk("R9 request after eight edges", irq_cnt - c0, 1);
    chk("R9 busy cleared", busy, 0);
    ext_byte(msb, rx2, cap);
    chk("R9 keeps shifting", rd_data, rx2);
    chk("R9 no extra request", irq_cnt - c0, 1);
    chk("R7 sdo still driven", sdo_oe, 1);
    ext_sel = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, first, c0;
    logic [7:0] txs [4];
    logic [7:0] rxs [4];
    txs[0] = 8'hA5; rxs[0] = 8'h3C;
    txs[1] = 8'h01; rxs[1] = 8'h80;
    txs[2] = 8'hFE; rxs[2] = 8'h6D;
    txs[3] = 8'h00; rxs[3] = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sck_out", sck_out, 1);
    chk("R1 sck_oe", sck_oe, 0);
    chk("R1 sdo_oe", sdo_oe, 1);
    chk("R1 rd_data", rd_data, 0);

    for (int sel = 0; sel < 4; sel++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 2; p++)
          xfer_int(sel, m[0], txs[(sel + p) % 4], rxs[(sel + 2 * p + m) % 4]);

    // R10: write lands on the eighth rising edge
    set_mode(4'b0100);
    s_msb = 1'b0; s_rx = 8'h5A;
    c0 = irq_cnt;
    wr(8'h11);
    repeat (63) @(negedge clk);
    wr(8'hC3);
    chk("R10 no request for abandoned byte", irq_cnt - c0, 0);
    chk("R10 busy stays", busy, 1);
    wait_irq(n, first);
    chk("R10 new transfer length", n, 64);
    chk("R10 new received byte", rd_data, 8'h5A);
    repeat (4) @(negedge clk);
    chk("R10 exactly one request", irq_cnt - c0, 1);

    xfer_ext(1'b0, 8'h96, 8'h2B, 8'hD4);
    xfer_ext(1'b1, 8'h4E, 8'hB1, 8'h07);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule